// File: doc/BRIEF.md
# Programmable Binary-Field Multiplier with Carry-Less Products

This block multiplies two operands either as elements of a binary extension field GF(2^m) or as plain carry-less polynomials. The field is chosen at run time: a configuration register holds the degree m and the reduction polynomial, which is the modulus with its top term x^m removed. Software writes the register once and then issues as many field multiplies as it needs. No modulus travels with each operation.

The datapath handles one multiplier bit per clock. On each step it may XOR the multiplicand into an accumulator, then shifts the multiplicand left by one. In field mode the reduction is folded into that shift: when the bit at position m becomes set, the reduction polynomial is XORed in and the bits at m and above are cleared. The same shift/XOR hardware also builds the full double-width carry-less product. Three carry-less forms are taken from it: the low half, the high half, and the reversed slice. An operation is started with a one-cycle `start` pulse. `busy` stays high while it runs, and `done` pulses when `result` holds the answer.

Top module: `gf2_mulunit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `result` are all 0. The configuration holds degree XLEN (64) and reduction polynomial 0.
- R2: A `start` sampled high with `busy` low is accepted. `busy` is high from the next cycle for exactly XLEN (64) cycles. `done` is high for exactly one cycle, XLEN cycles after the accepting edge, and `busy` is low at that point.
- R3: A `start` pulse while `busy` is high is ignored. The running operation keeps its timing and its result.
- R4: `op` is decoded as follows: 2'b00 field multiply, 2'b01 carry-less low, 2'b10 carry-less high, 2'b11 carry-less reversed.
- R5: A field multiply returns a·b mod (x^m + reduction polynomial). With m=3 and modulus 0b1011, every pair below 8 is correct, including 0b111·0b101 = 0b110. The same holds for m=4 with modulus 0b10011.
- R6: With m=8 and modulus 0b100011011, 0x80·0x83 = 0x01, and the other sample products are correct.
- R7: In field mode, operand bits at or above the degree are ignored, and the result is always below 2^m.
- R8: Carry-less low returns bits XLEN-1..0 of the full carry-less product of a and b.
- R9: Carry-less high returns bits 2·XLEN-1..XLEN of the full carry-less product.
- R10: Carry-less reversed returns bits 2·XLEN-2..XLEN-1 of the full carry-less product.
- R11: A configuration write with `cfg_deg` from 1 to XLEN updates both degree and polynomial. A write with degree 0 or above XLEN is ignored as a whole.
- R12: The configuration is captured when an operation is accepted. Writes made while `busy` is high affect only later operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_deg | input | 7 | Field degree m to write (1..64) |
| cfg_poly | input | 64 | Reduction polynomial to write (modulus without x^m) |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 2 | Operation select, encoded as in R4 |
| opa | input | 64 | Multiplicand |
| opb | input | 64 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 64 | Registered result |

## Verification
Every result is due exactly 64 clock edges after the edge that accepts `start`. The bench counts edges from that acceptance, samples on falling edges, and requires `done` at count 64 and not at any earlier count. It requires `done` to be low again one edge later, so a shifted or stretched pulse shows up as a timing failure rather than as a late but correct value. Configuration writes are issued only on falling edges, and their effect is judged at the `result` of the next operation.

// File: rtl/gf2_pkg.sv
package gf2_pkg;
  typedef enum logic [1:0] {
    OP_FIELD  = 2'b00,
    OP_CL_LO  = 2'b01,
    OP_CL_HI  = 2'b10,
    OP_CL_REV = 2'b11
  } gf2_op_e;
endpackage

// File: rtl/gf2_cfg.sv
module gf2_cfg #(
  parameter int XLEN  = 64,
  parameter int DEG_W = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [DEG_W-1:0] wr_deg,
  input  logic [XLEN-1:0]  wr_poly,
  output logic [DEG_W-1:0] deg,
  output logic [XLEN-1:0]  poly
);
  localparam logic [DEG_W-1:0] DEG_MAX = DEG_W'(XLEN);

  logic wr_ok;
  assign wr_ok = we && (wr_deg != '0) && (wr_deg <= DEG_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      deg  <= DEG_MAX;
      poly <= '0;
    end else if (wr_ok) begin
      deg  <= wr_deg;
      poly <= wr_poly;
    end
  end

  // R11: the stored degree always stays within 1..XLEN
  p_deg_range_r11: assert property (@(posedge clk) disable iff (rst)
    (deg != '0) && (deg <= DEG_MAX));

  // R11: an out-of-range degree leaves the whole register untouched
  p_bad_write_r11: assert property (@(posedge clk) disable iff (rst)
    (we && ((wr_deg == '0) || (wr_deg > DEG_MAX))) |=> ($stable(deg) && $stable(poly)));
endmodule

// File: rtl/gf2_seq.sv
module gf2_seq #(
  parameter int XLEN  = 64,
  parameter int CNT_W = $clog2(XLEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic last,
  output logic done
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XLEN - 1);

  logic [CNT_W-1:0] cnt;

  assign accept = start && !busy;
  assign last   = busy && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R2: done lasts one cycle only
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: busy drops exactly when done rises
  p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: the step counter never runs past the last step
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CNT_LAST));

  // R3: a start during a run neither restarts nor ends it
  p_ignore_start_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> (busy && !done));
endmodule

// File: rtl/gf2_step.sv
module gf2_step #(
  parameter int XLEN  = 64,
  parameter int DEG_W = $clog2(XLEN + 1),
  localparam int W    = 2 * XLEN
) (
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     acc,
  input  logic             mbit,
  input  logic             field,
  input  logic [DEG_W-1:0] deg,
  input  logic [XLEN-1:0]  poly,
  output logic [W-1:0]     mcand_nx,
  output logic [W-1:0]     acc_nx
);
  logic [W-1:0] shifted;
  logic [W-1:0] keep;
  logic [W-1:0] red;

  always_comb begin
    acc_nx  = mbit ? (acc ^ mcand) : acc;
    shifted = mcand << 1;
    keep    = ~({W{1'b1}} << deg);
    red     = {{XLEN{1'b0}}, poly} & keep;
    if (field) begin
      mcand_nx = (shifted & keep) ^ (shifted[deg] ? red : '0);
    end else begin
      mcand_nx = shifted;
    end
  end
endmodule

// File: rtl/gf2_mulunit.sv
module gf2_mulunit #(
  parameter int XLEN  = 64,
  parameter int DEG_W = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DEG_W-1:0] cfg_deg,
  input  logic [XLEN-1:0]  cfg_poly,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  result
);
  import gf2_pkg::*;

  localparam int W = 2 * XLEN;

  logic [DEG_W-1:0] cur_deg;
  logic [XLEN-1:0]  cur_poly;
  logic             accept;
  logic             last;

  logic [W-1:0]     mcand_r, acc_r;
  logic [W-1:0]     mcand_nx, acc_nx;
  logic [XLEN-1:0]  mplier_r;
  gf2_op_e          op_r;
  logic [DEG_W-1:0] deg_r;
  logic [XLEN-1:0]  poly_r;
  logic [XLEN-1:0]  in_mask;
  logic [XLEN-1:0]  out_mask;
  logic             field_in;

  gf2_cfg #(.XLEN(XLEN), .DEG_W(DEG_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_deg(cfg_deg), .wr_poly(cfg_poly),
    .deg(cur_deg), .poly(cur_poly)
  );

  gf2_seq #(.XLEN(XLEN), .CNT_W(DEG_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .busy(busy), .last(last), .done(done)
  );

  gf2_step #(.XLEN(XLEN), .DEG_W(DEG_W)) u_step (
    .mcand(mcand_r), .acc(acc_r), .mbit(mplier_r[0]),
    .field(op_r == OP_FIELD), .deg(deg_r), .poly(poly_r),
    .mcand_nx(mcand_nx), .acc_nx(acc_nx)
  );

  assign field_in = (gf2_op_e'(op) == OP_FIELD);
  assign in_mask  = field_in ? ~({XLEN{1'b1}} << cur_deg) : {XLEN{1'b1}};
  assign out_mask = ~({XLEN{1'b1}} << deg_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_r  <= '0;
      acc_r    <= '0;
      mplier_r <= '0;
      op_r     <= OP_FIELD;
      deg_r    <= DEG_W'(XLEN);
      poly_r   <= '0;
      result   <= '0;
    end else if (accept) begin
      mcand_r  <= {{XLEN{1'b0}}, opa & in_mask};
      mplier_r <= opb & in_mask;
      acc_r    <= '0;
      op_r     <= gf2_op_e'(op);
      deg_r    <= cur_deg;
      poly_r   <= cur_poly;
    end else if (busy) begin
      mcand_r  <= mcand_nx;
      acc_r    <= acc_nx;
      mplier_r <= mplier_r >> 1;
      if (last) begin
        unique case (op_r)
          OP_CL_HI:  result <= acc_nx[W-1:XLEN];
          OP_CL_REV: result <= acc_nx[W-2:XLEN-1];
          default:   result <= acc_nx[XLEN-1:0];
        endcase
      end
    end
  end

  // R7: a field product never has bits at or above the degree
  p_field_range_r7: assert property (@(posedge clk) disable iff (rst)
    (done && (op_r == OP_FIELD)) |-> ((result & ~out_mask) == '0));

  // R12: the captured configuration holds for the whole run
  p_snapshot_r12: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> ($stable(deg_r) && $stable(poly_r) && $stable(op_r)));

  // R1: result only changes when an operation completes
  p_result_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result) || $past(last));
endmodule

// File: tb/gf2_mulunit_test.sv
module gf2_mulunit_test;
  localparam int XLEN = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_deg = '0;
  logic [63:0] cfg_poly = '0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  gf2_mulunit uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_deg(cfg_deg), .cfg_poly(cfg_poly),
    .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] clprod(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++)
      if (b[i]) p ^= ({64'd0, a} << i);
    return p;
  endfunction

  // full product first, then long division by the modulus
  function automatic logic [63:0] fmul(input logic [63:0] a, input logic [63:0] b,
                                       input int m, input logic [63:0] rp);
    logic [127:0] p, md;
    logic [63:0]  lo;
    lo = (m >= 64) ? '1 : ((64'd1 << m) - 1);
    p  = clprod(a & lo, b & lo);
    md = ({64'd0, rp & lo}) | (128'd1 << m);
    for (int i = 126; i >= m; i--)
      if (p[i]) p ^= md << (i - m);
    return p[63:0];
  endfunction

  task automatic cfg(input int m, input logic [63:0] rp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_deg = 7'(m); cfg_poly = rp;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // launch, count edges from the accepting edge, check timing
  task automatic run(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b,
                     output logic [63:0] res);
    int lat;
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 64, "R2 latency", 64'(lat), 64'd64);
    res = result;
    @(negedge clk);
    chk(!done && !busy, "R2 done pulse width", {62'd0, done, busy}, 64'd0);
  endtask

  logic [63:0] r, ea, eb, lfsr;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", {62'd0, busy, done}, 64'd0);
    chk(result == 64'd0, "R1 reset result", result, 64'd0);

    // R1: default config is degree 64, poly 0, so a field multiply equals the low carry-less half
    run(2'b00, 64'h8000_0000_0000_0001, 64'h3, r);
    chk(r == clprod(64'h8000_0000_0000_0001, 64'h3)[63:0], "R1 default config", r,
        clprod(64'h8000_0000_0000_0001, 64'h3)[63:0]);

    // R5: exhaustive GF(2^3), modulus 0b1011
    cfg(3, 64'h3);
    run(2'b00, 64'd7, 64'd5, r);
    chk(r == 64'd6, "R5 7*5 in GF(8)", r, 64'd6);
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        run(2'b00, 64'(x), 64'(y), r);
        chk(r == fmul(64'(x), 64'(y), 3, 64'h3), "R5 GF(8) sweep", r, fmul(64'(x), 64'(y), 3, 64'h3));
      end

    // R7: high operand bits ignored in field mode
    run(2'b00, 64'hFFFF_FFFF_FFFF_FFF7, 64'hABCD_0000_0000_0005, r);
    chk(r == 64'd6, "R7 upper bits masked", r, 64'd6);

    // R11: out-of-range degree writes ignored
    cfg(0, 64'h1B);
    run(2'b00, 64'd7, 64'd5, r);
    chk(r == 64'd6, "R11 degree 0 ignored", r, 64'd6);
    cfg(65, 64'h1B);
    run(2'b00, 64'd7, 64'd5, r);
    chk(r == 64'd6, "R11 degree 65 ignored", r, 64'd6);

    // R5: exhaustive GF(2^4), modulus 0b10011
    cfg(4, 64'h3);
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        run(2'b00, 64'(x), 64'(y), r);
        chk(r == fmul(64'(x), 64'(y), 4, 64'h3), "R5 GF(16) sweep", r, fmul(64'(x), 64'(y), 4, 64'h3));
      end

    // R6: AES field
    cfg(8, 64'h1B);
    run(2'b00, 64'h80, 64'h83, r);
    chk(r == 64'h01, "R6 0x80*0x83", r, 64'h01);
    for (int k = 0; k < 12; k++) begin
      ea = 64'((k * 37 + 11) & 255); eb = 64'((k * 91 + 200) & 255);
      run(2'b00, ea, eb, r);
      chk(r == fmul(ea, eb, 8, 64'h1B), "R6 AES samples", r, fmul(ea, eb, 8, 64'h1B));
    end

    // R3: start pulse during a run is ignored
    @(negedge clk);
    start = 1'b1; op = 2'b00; opa = 64'h80; opb = 64'h83;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat = 0;
      while (!done && lat < 200) begin
        @(negedge clk);
        lat++;
        if (lat == 10) begin start = 1'b1; opa = 64'h57; opb = 64'h13; end
        if (lat == 11) start = 1'b0;
      end
      chk(lat == 64, "R3 latency unchanged", 64'(lat), 64'd64);
      chk(result == 64'h01, "R3 result unchanged", result, 64'h01);
      @(negedge clk);
      chk(!busy, "R3 no restart", {63'd0, busy}, 64'd0);
    end

    // R12: config write during run applies only later
    @(negedge clk);
    start = 1'b1; op = 2'b00; opa = 64'h80; opb = 64'h83;
    @(negedge clk);
    start = 1'b0;
    cfg_we = 1'b1; cfg_deg = 7'd3; cfg_poly = 64'h3;
    @(negedge clk);
    cfg_we = 1'b0;
    while (!done) @(negedge clk);
    chk(result == 64'h01, "R12 running op keeps AES config", result, 64'h01);
    run(2'b00, 64'd7, 64'd5, r);
    chk(r == 64'd6, "R12 next op uses new config", r, 64'd6);

    // R4 R8 R9 R10: carry-less forms on assorted patterns
    lfsr = 64'hACE1_2468_1357_9BDF;
    for (int k = 0; k < 16; k++) begin
      case (k)
        0: begin ea = '1; eb = '1; end
        1: begin ea = 64'h8000_0000_0000_0000; eb = 64'h8000_0000_0000_0000; end
        2: begin ea = 64'd1; eb = 64'hDEAD_BEEF_0123_4567; end
        3: begin ea = 64'd0; eb = '1; end
        default: begin
          lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
          ea = lfsr ^ 64'(k * 64'h9E37_79B9);
          lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
          eb = {lfsr[31:0], lfsr[63:32]};
        end
      endcase
      run(2'b01, ea, eb, r);
      chk(r == clprod(ea, eb)[63:0], "R8 carry-less low", r, clprod(ea, eb)[63:0]);
      run(2'b10, ea, eb, r);
      chk(r == clprod(ea, eb)[127:64], "R9 carry-less high", r, clprod(ea, eb)[127:64]);
      run(2'b11, ea, eb, r);
      chk(r == clprod(ea, eb)[126:63], "R10 carry-less reversed", r, clprod(ea, eb)[126:63]);
    end

    // R4: carry-less modes are not masked by the small field degree
    run(2'b01, 64'hF0, 64'h3, r);
    chk(r == 64'h110, "R4 op 01 unmasked", r, 64'h110);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule